// File: doc/BRIEF.md
# 16-bit Address Adder with Condition Flags

This block is the address arithmetic unit of a small 8-bit processor core. It performs two kinds of 16-bit addition and returns the sum together with four condition flags: zero, subtract, half-carry and carry. The first kind adds a signed 8-bit displacement to a 16-bit register value. The core uses it both to adjust the stack pointer and to load an offset pointer into a register pair. The second kind adds two 16-bit register-pair values.

The core's decoder sets the operation select and both operands, together with the current zero flag, and raises `start` for one cycle. On the next clock edge the unit captures the sum, the new flags and the instruction length (`pc_inc`), and it raises `done` for one cycle. The outputs then hold until the next start. Instruction decode, the register file and memory access sit outside the block.

Top module: `addr_flag_alu`

## Requirements
- R1: With `op_sel`=0 (displacement), `result` is `opnd_a` plus `opnd_b[7:0]` sign-extended to 16 bits, modulo 2^16. Examples: 0x0000 plus 0xFF gives 0xFFFF, and 0xFFFF plus 0x01 gives 0x0000.
- R2: In the displacement operation, the zero flag (`flags_out[3]`) and the subtract flag (`flags_out[2]`) are always 0.
- R3: In the displacement operation, the carry flag (`flags_out[0]`) is 1 exactly when `opnd_a[7:0]` + `opnd_b[7:0]`, both taken as unsigned, is above 0xFF.
- R4: In the displacement operation, the half-carry flag (`flags_out[1]`) is 1 exactly when `opnd_a[3:0]` + `opnd_b[3:0]` is above 0xF.
- R5: With `op_sel`=1 (pair add), `result` is `opnd_a` + `opnd_b` modulo 2^16. Half-carry is 1 exactly when the sum of the two low 12-bit fields is above 0xFFF.
- R6: In the pair add, carry is 1 only when the full sum is above 0xFFFF. A carry out of the low byte alone leaves it 0.
- R7: In the pair add, `flags_out[3]` equals the `flag_z_in` that was captured and `flags_out[2]` is 0.
- R8: `pc_inc` is 2 after a displacement operation and 1 after a pair add.
- R9: A high `start` at a rising edge loads `result`, `flags_out` and `pc_inc` at that edge and makes `done` 1 for the following cycle only. While `start` is low, the outputs keep their values and `done` is 0.
- R10: A synchronous active-high `rst` clears `result`, `flags_out`, `pc_inc` and `done` to 0.
- R11: In the displacement operation, `opnd_b[15:8]` has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture strobe for one operation |
| op_sel | input | 1 | 0 = displacement add, 1 = register-pair add |
| opnd_a | input | 16 | Register value (base or first pair) |
| opnd_b | input | 16 | Second pair, or displacement in bits 7:0 |
| flag_z_in | input | 1 | Current zero flag, passed through by the pair add |
| result | output | 16 | Registered sum |
| flags_out | output | 4 | Registered flags {Z, N, H, C} |
| pc_inc | output | 2 | Instruction length of the captured operation |
| done | output | 1 | One-cycle pulse after a capture |

## Verification
The displacement add is tried with positive and negative offsets on base values whose low byte is 0x00, 0x0F, 0x01 and 0xFF. These cases separate carry out of bit 3 from carry out of bit 7. They also separate both from the unrelated carry out of bit 15, because 0x7FFF+1 sets the flags while 0x0000+0xFF sets nothing. Pair adds with carries out of bit 7, bit 11 and bit 15 show that only bit 11 and bit 15 matter. A zero flag of 1 fed into a pair add shows that it is passed through rather than recomputed. Random operands with garbage in the upper displacement byte, and idle cycles between operations, cover the ignore and hold rules.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;
  typedef enum logic {
    OP_DISP = 1'b0,
    OP_PAIR = 1'b1
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FL_Z = 3;
  localparam int FL_N = 2;
  localparam int FL_H = 1;
  localparam int FL_C = 0;

  localparam int PCI_W = 2;
  localparam logic [PCI_W-1:0] PCI_DISP = 2'd2;
  localparam logic [PCI_W-1:0] PCI_PAIR = 2'd1;
endpackage

// File: rtl/disp_adder.sv
module disp_adder #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0]                base_i,
  input  logic [OFS_W-1:0]                 ofs_i,
  output logic [DATA_W-1:0]                sum_o,
  output logic [addr_alu_pkg::FLAG_W-1:0]  flags_o
);
  import addr_alu_pkg::*;
  localparam int EXT_W = DATA_W - OFS_W;

  function automatic logic [DATA_W-1:0] f_disp_sum(
      input logic [DATA_W-1:0] b, input logic [OFS_W-1:0] o);
    logic [DATA_W-1:0] ext;
    ext = {{EXT_W{o[OFS_W-1]}}, o};
    return b + ext;
  endfunction

  function automatic logic f_low_carry(
      input logic [OFS_W-1:0] x, input logic [OFS_W-1:0] y);
    logic [OFS_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[OFS_W];
  endfunction

  function automatic logic f_nib_carry(
      input logic [NIB_W-1:0] x, input logic [NIB_W-1:0] y);
    logic [NIB_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[NIB_W];
  endfunction

  logic byte_cy;
  logic nib_cy;

  always_comb begin
    sum_o   = f_disp_sum(base_i, ofs_i);
    byte_cy = f_low_carry(base_i[OFS_W-1:0], ofs_i);
    nib_cy  = f_nib_carry(base_i[NIB_W-1:0], ofs_i[NIB_W-1:0]);
    flags_o       = '0;
    flags_o[FL_H] = nib_cy;
    flags_o[FL_C] = byte_cy;
  end
endmodule

// File: rtl/pair_adder.sv
module pair_adder #(
  parameter int DATA_W = 16,
  parameter int HC_W   = 12
) (
  input  logic [DATA_W-1:0]                a_i,
  input  logic [DATA_W-1:0]                b_i,
  input  logic                             z_i,
  output logic [DATA_W-1:0]                sum_o,
  output logic [addr_alu_pkg::FLAG_W-1:0]  flags_o
);
  import addr_alu_pkg::*;

  function automatic logic [DATA_W:0] f_wide_sum(
      input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic f_field_carry(
      input logic [HC_W-1:0] x, input logic [HC_W-1:0] y);
    logic [HC_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[HC_W];
  endfunction

  logic [DATA_W:0] wide;
  logic            top_cy;
  logic            fld_cy;

  always_comb begin
    wide   = f_wide_sum(a_i, b_i);
    top_cy = wide[DATA_W];
    fld_cy = f_field_carry(a_i[HC_W-1:0], b_i[HC_W-1:0]);
    sum_o  = wide[DATA_W-1:0];
    flags_o       = '0;
    flags_o[FL_Z] = z_i;
    flags_o[FL_H] = fld_cy;
    flags_o[FL_C] = top_cy;
  end
endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg #(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             load_i,
  input  logic [DATA_W-1:0]                sum_i,
  input  logic [addr_alu_pkg::FLAG_W-1:0]  flags_i,
  input  logic [addr_alu_pkg::PCI_W-1:0]   pci_i,
  output logic [DATA_W-1:0]                sum_q,
  output logic [addr_alu_pkg::FLAG_W-1:0]  flags_q,
  output logic [addr_alu_pkg::PCI_W-1:0]   pci_q,
  output logic                             done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      flags_q <= '0;
      pci_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= load_i;
      if (load_i) begin
        sum_q   <= sum_i;
        flags_q <= flags_i;
        pci_q   <= pci_i;
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    load_i |=> done_q);
  a_r9_no_done: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> !done_q);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(sum_q) && $stable(flags_q) && $stable(pci_q)));
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!done_q && sum_q == '0 && flags_q == '0 && pci_q == '0));
endmodule

// File: rtl/addr_flag_alu.sv
module addr_flag_alu #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              flag_z_in,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic [1:0]        pc_inc,
  output logic              done
);
  import addr_alu_pkg::*;
  localparam int NIB_W = 4;
  localparam int HC_W  = DATA_W - NIB_W;

  logic [DATA_W-1:0] disp_sum, pair_sum, sel_sum;
  logic [FLAG_W-1:0] disp_fl, pair_fl, sel_fl;
  logic [PCI_W-1:0]  sel_pci;
  alu_op_e           op;

  assign op = alu_op_e'(op_sel);

  disp_adder #(.DATA_W(DATA_W), .OFS_W(OFS_W), .NIB_W(NIB_W)) u_disp (
    .base_i (opnd_a),
    .ofs_i  (opnd_b[OFS_W-1:0]),
    .sum_o  (disp_sum),
    .flags_o(disp_fl)
  );

  pair_adder #(.DATA_W(DATA_W), .HC_W(HC_W)) u_pair (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .z_i    (flag_z_in),
    .sum_o  (pair_sum),
    .flags_o(pair_fl)
  );

  always_comb begin
    if (op == OP_PAIR) begin
      sel_sum = pair_sum;
      sel_fl  = pair_fl;
      sel_pci = PCI_PAIR;
    end else begin
      sel_sum = disp_sum;
      sel_fl  = disp_fl;
      sel_pci = PCI_DISP;
    end
  end

  alu_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load_i (start),
    .sum_i  (sel_sum),
    .flags_i(sel_fl),
    .pci_i  (sel_pci),
    .sum_q  (result),
    .flags_q(flags_out),
    .pci_q  (pc_inc),
    .done_q (done)
  );

  a_r2_disp_zn_clear: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b0) |=> (flags_out[FL_Z] == 1'b0 && flags_out[FL_N] == 1'b0));
  a_r7_pair_zero_kept: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b1) |=> (flags_out[FL_Z] == $past(flag_z_in) && !flags_out[FL_N]));
  a_r8_len_disp: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b0) |=> (pc_inc == 2'd2));
  a_r8_len_pair: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b1) |=> (pc_inc == 2'd1));
  a_r3_disp_carry: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b0 && opnd_a[OFS_W-1:0] == '0) |=> !flags_out[FL_C]);
  a_r6_pair_carry: assert property (@(posedge clk) disable iff (rst)
    (start && op_sel == 1'b1 && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1]) |=> !flags_out[FL_C]);
endmodule

// File: tb/sim_addr_flag_alu.sv
module sim_addr_flag_alu;
  logic        clk = 1'b0;
  logic        rst, start, op_sel, flag_z_in;
  logic [15:0] opnd_a, opnd_b;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic [1:0]  pc_inc;
  logic        done;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  addr_flag_alu u0 (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_z_in(flag_z_in),
    .result(result), .flags_out(flags_out), .pc_inc(pc_inc), .done(done)
  );

  function automatic logic [15:0] ref_sum(input bit pair, input int a, input int b);
    int ofs;
    if (pair) return 16'((a + b) % 65536);
    ofs = (b & 255) >= 128 ? (b & 255) - 256 : (b & 255);
    return 16'((a + ofs + 65536) % 65536);
  endfunction

  function automatic logic [3:0] ref_flags(input bit pair, input int a, input int b, input bit z);
    bit h, c;
    if (pair) begin
      h = ((a % 4096) + (b % 4096)) >= 4096;
      c = (a + b) >= 65536;
      return {z, 1'b0, h, c};
    end
    h = ((a % 16) + (b % 16)) >= 16;
    c = ((a % 256) + (b % 256)) >= 256;
    return {2'b00, h, c};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit pair, input logic [15:0] a, input logic [15:0] b,
                        input bit z, input string req);
    @(negedge clk);
    op_sel = pair; opnd_a = a; opnd_b = b; flag_z_in = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, int'(done), 1);
    chk({req, " result"}, int'(result), int'(ref_sum(pair, int'(a), int'(b))));
    chk({req, " flags"}, int'(flags_out), int'(ref_flags(pair, int'(a), int'(b), z)));
    chk({req, " R8 pc_inc"}, int'(pc_inc), pair ? 1 : 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep_r;
    logic [3:0]  keep_f;
    logic [15:0] r1;
    logic [3:0]  f1;
    void'($urandom(32'd12345));
    rst = 1'b1; start = 1'b0; op_sel = 1'b0; opnd_a = '0; opnd_b = '0; flag_z_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset result", int'(result), 0);
    chk("R10 reset flags", int'(flags_out), 0);
    chk("R10 reset pc_inc/done", int'({pc_inc, done}), 0);
    rst = 1'b0;

    run_op(1'b0, 16'h0000, 16'h00FF, 1'b1, "R1 R2 0000+FF");
    run_op(1'b0, 16'hFFFF, 16'h0001, 1'b1, "R1 R3 FFFF+01");
    run_op(1'b0, 16'h7FFF, 16'h0001, 1'b0, "R3 7FFF+01");
    run_op(1'b0, 16'h0100, 16'h0001, 1'b1, "R3 0100+01");
    run_op(1'b0, 16'h000F, 16'h0001, 1'b0, "R4 000F+01");
    run_op(1'b0, 16'h0001, 16'h00FF, 1'b1, "R4 0001+FF");
    run_op(1'b0, 16'h0064, 16'h00FB, 1'b0, "R1 0064-5");
    run_op(1'b1, 16'h0001, 16'h00FF, 1'b0, "R6 0001+00FF");
    run_op(1'b1, 16'h2608, 16'h2608, 1'b1, "R7 2608+2608");
    run_op(1'b1, 16'h000F, 16'h0001, 1'b0, "R5 000F+0001");
    run_op(1'b1, 16'h0800, 16'h0800, 1'b0, "R5 0800+0800");
    run_op(1'b1, 16'hF000, 16'h1000, 1'b1, "R6 F000+1000");

    // R11: upper byte of displacement operand ignored
    run_op(1'b0, 16'h12F8, 16'h0009, 1'b0, "R11 base");
    r1 = result; f1 = flags_out;
    run_op(1'b0, 16'h12F8, 16'hAB09, 1'b0, "R11 dirty");
    chk("R11 same result", int'(result), int'(r1));
    chk("R11 same flags", int'(flags_out), int'(f1));

    // R9: hold while start low
    keep_r = result; keep_f = flags_out;
    @(negedge clk);
    op_sel = 1'b1; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF; flag_z_in = 1'b1;
    chk("R9 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R9 hold result", int'(result), int'(keep_r));
    chk("R9 hold flags", int'(flags_out), int'(keep_f));
    chk("R9 no done", int'(done), 0);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] ra, rb;
      bit rp, rz;
      ra = 16'($urandom); rb = 16'($urandom);
      rp = 1'($urandom); rz = 1'($urandom);
      run_op(rp, ra, rb, rz, rp ? "R5 R6 R7 random" : "R1 R2 R3 R4 random");
    end

    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid reset result", int'(result), 0);
    chk("R10 mid reset flags", int'(flags_out), 0);
    chk("R10 mid reset done", int'(done), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule